// File: doc/BRIEF.md
# Snooping MESI line-state controller

This block is the coherence controller of one write-back cache on a shared, atomic bus. It keeps a four-state (Invalid, Shared, Exclusive, Modified) record and a tag for every line of a small direct-mapped array. Processor loads and stores are served from that record when possible. Otherwise the controller runs one bus transaction at a time (read, read-exclusive, data-less upgrade or write-back) and holds the processor until that transaction completes.

The controller also watches the transactions that other caches place on the bus. For each one it drives its part of a wired-OR shared line and raises flush and data-supply pulses. It then moves the matching line to its new state. The data array, arbitration and memory are outside the block. Grants and data beats arrive as single-cycle input pulses, and flushes and data supply leave as single-cycle output pulses. A run-time input selects whether clean lines supply data to other caches.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: A load miss issues a bus read (cmd 0) for the request address. At the data beat the line is installed as Exclusive (state code 2) if `shared_in` is low, or as Shared (state code 1) if it is high. `cpu_done` pulses one cycle after the data beat.
- R2: A load hit and a store to an Exclusive or Modified line complete one cycle after acceptance with no bus request. A load leaves the state unchanged. A store leaves the line Modified (state code 3).
- R3: A store to a line that is absent or Invalid issues a read-exclusive (cmd 1), holds address and command until granted, and installs the line Modified.
- R4: A store to a Shared line issues an upgrade (cmd 2) that completes one cycle after its grant with no data beat. The line becomes Modified.
- R5: A snooped read (cmd 0) that hits a Modified line asserts `snp_flush`, `snp_supply` and `snp_shared` in the same cycle, and the line becomes Shared.
- R6: A snooped read-exclusive (cmd 1) invalidates a hit line in any valid state, with a flush only from Modified. A snooped upgrade (cmd 2) invalidates a Shared line.
- R7: A snooped read that hits an Exclusive line demotes it to Shared.
- R8: `snp_shared` is high in a snoop cycle only when the snooped line is valid here and the command is 0, 1 or 2. A snooped write-back (cmd 3) and a snoop miss leave the outputs low and the line unchanged.
- R9: With `c2c_en` high, a snooped read or read-exclusive that hits a Shared or Exclusive line asserts `snp_supply` without `snp_flush`. With `c2c_en` low such a hit asserts neither.
- R10: A miss that replaces a Modified line first issues a write-back (cmd 3) of the victim's address, then the fill. Replacing a Shared or Exclusive line issues only the fill.
- R11: After reset every line is Invalid, so a first access misses and a first snoop sees no hit.
- R12: A processor request offered in a snoop cycle is not accepted in that cycle. A pending upgrade whose line is invalidated by a snoop before its grant is reissued as a read-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| c2c_en | input | 1 | Allow clean lines to supply data to other caches |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_line_st | output | 2 | Line state after the completed request (0 I, 1 S, 2 E, 3 M) |
| bus_req | output | 1 | Own transaction pending |
| bus_cmd | output | 2 | Own command: 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| bus_addr | output | ADDR_W | Address of the own transaction |
| bus_gnt | input | 1 | Own transaction placed on the bus (pulse) |
| bus_data_vld | input | 1 | Data beat for an own read or read-exclusive (pulse) |
| shared_in | input | 1 | Wired-OR shared line from the other caches, sampled at the data beat |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache's contribution to the shared line |
| snp_flush | output | 1 | Flush pulse: dirty data goes to the bus and memory |
| snp_supply | output | 1 | This cache supplies the data for the snooped transaction |

## Verification
Snoop responses are combinational, so the bench reads them in the snoop cycle itself. It then confirms the new line state through a later load, whose `cpu_done` shows the state in `cpu_line_st`. Every processor result is due exactly one cycle after its last stimulus: the acceptance for hits, the grant for an upgrade, and the data beat for fills. The bench's bus model counts the cycles since it last drove a grant or data beat and checks that `cpu_done` arrives at a count of one. The two ordering cases place a snoop in the acceptance cycle, or between an upgrade request and its grant, and check the delayed completion and the reissued command.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RDX = 2'd1,
    BC_UPG = 2'd2,
    BC_WB  = 2'd3
  } bus_cmd_t;

  typedef enum logic [2:0] {
    P_IDLE,
    P_UPG,
    P_WB,
    P_FILL,
    P_DATA
  } pstate_t;

  typedef struct packed {
    line_st_t nxt;
    logic     upd;
    logic     flush;
    logic     supply;
    logic     shared;
  } snp_resp_t;

  // Reaction of a line in state st to another cache's command
  function automatic snp_resp_t snoop_eval(input line_st_t st, input bus_cmd_t cmd,
                                           input logic c2c);
    snp_resp_t r;
    r.nxt    = st;
    r.upd    = 1'b0;
    r.flush  = 1'b0;
    r.supply = 1'b0;
    r.shared = 1'b0;
    if (st != ST_I) begin
      case (cmd)
        BC_RD: begin
          r.shared = 1'b1;
          r.flush  = (st == ST_M);
          r.supply = (st == ST_M) || c2c;
          r.nxt    = ST_S;
          r.upd    = (st != ST_S);
        end
        BC_RDX: begin
          r.shared = 1'b1;
          r.flush  = (st == ST_M);
          r.supply = (st == ST_M) || c2c;
          r.nxt    = ST_I;
          r.upd    = 1'b1;
        end
        BC_UPG: begin
          r.shared = 1'b1;
          r.nxt    = ST_I;
          r.upd    = 1'b1;
        end
        default: ;
      endcase
    end
    return r;
  endfunction

  // State a fill installs
  function automatic line_st_t fill_state(input logic is_store, input logic shared_seen);
    if (is_store)
      return ST_M;
    return shared_seen ? ST_S : ST_E;
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output line_st_t         rd_st,
  output logic [TAG_W-1:0] rd_tag,
  input  logic [IDX_W-1:0] sn_idx,
  output line_st_t         sn_st,
  output logic [TAG_W-1:0] sn_tag,
  input  logic             pw_en,
  input  line_st_t         pw_st,
  input  logic [TAG_W-1:0] pw_tag,
  input  logic             sw_en,
  input  line_st_t         sw_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_t         st_a  [LINES];
  logic [TAG_W-1:0] tag_a [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t         st_q;
    logic [TAG_W-1:0] tag_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q  <= ST_I;
        tag_q <= '0;
      end else if (pw_en && rd_idx == IDX_W'(g)) begin
        st_q  <= pw_st;
        tag_q <= pw_tag;
      end else if (sw_en && sn_idx == IDX_W'(g)) begin
        st_q  <= sw_st;
      end
    end
    assign st_a[g]  = st_q;
    assign tag_a[g] = tag_q;
  end

  assign rd_st  = st_a[rd_idx];
  assign rd_tag = tag_a[rd_idx];
  assign sn_st  = st_a[sn_idx];
  assign sn_tag = tag_a[sn_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 9
) (
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_t         line_st,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             c2c_en,
  output logic             hit,
  output logic             shared_o,
  output logic             flush_o,
  output logic             supply_o,
  output logic             wr_en,
  output line_st_t         wr_st
);
  snp_resp_t resp;

  always_comb begin
    hit      = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
    resp     = snoop_eval(line_st, bus_cmd_t'(snp_cmd), c2c_en);
    shared_o = hit && resp.shared;
    flush_o  = hit && resp.flush;
    supply_o = hit && resp.supply;
    wr_en    = hit && resp.upd;
    wr_st    = resp.nxt;
  end
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              snp_valid,
  input  logic              bus_gnt,
  input  logic              bus_data_vld,
  input  logic              shared_in,
  input  line_st_t          lk_st,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [IDX_W-1:0]  lk_idx,
  output logic              bus_req,
  output bus_cmd_t          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              pw_en,
  output line_st_t          pw_st,
  output logic [TAG_W-1:0]  pw_tag,
  output logic              cpu_done,
  output line_st_t          cpu_line_st,
  output logic              fill_evt,
  output logic              fill_store,
  output logic              req_accept
);
  pstate_t           ps, ps_n;
  logic              rq_we;
  logic [ADDR_W-1:0] rq_addr;
  logic              done_q, done_d;
  line_st_t          res_q, res_d;
  logic [TAG_W-1:0]  want_tag;
  logic              hit;

  always_comb begin
    ps_n     = ps;
    done_d   = 1'b0;
    res_d    = res_q;
    pw_en    = 1'b0;
    pw_st    = ST_I;
    pw_tag   = lk_tag;
    bus_req  = 1'b0;
    bus_cmd  = BC_RD;
    bus_addr = rq_addr;
    fill_evt = 1'b0;
    lk_idx   = (ps == P_IDLE) ? cpu_addr[IDX_W-1:0] : rq_addr[IDX_W-1:0];
    want_tag = (ps == P_IDLE) ? cpu_addr[ADDR_W-1:IDX_W] : rq_addr[ADDR_W-1:IDX_W];
    hit      = (lk_st != ST_I) && (lk_tag == want_tag);
    req_accept = (ps == P_IDLE) && cpu_req && !snp_valid && !done_q;

    case (ps)
      P_IDLE: if (req_accept) begin
        if (hit && !cpu_we) begin
          done_d = 1'b1;
          res_d  = lk_st;
        end else if (hit && lk_st != ST_S) begin
          pw_en  = 1'b1;
          pw_st  = ST_M;
          done_d = 1'b1;
          res_d  = ST_M;
        end else if (hit) begin
          ps_n = P_UPG;
        end else if (lk_st == ST_M) begin
          ps_n = P_WB;
        end else begin
          pw_en = (lk_st != ST_I);
          ps_n  = P_FILL;
        end
      end
      P_UPG: begin
        bus_req = (lk_st == ST_S);
        bus_cmd = BC_UPG;
        if (lk_st != ST_S) begin
          ps_n = P_FILL;
        end else if (bus_gnt) begin
          pw_en  = 1'b1;
          pw_st  = ST_M;
          done_d = 1'b1;
          res_d  = ST_M;
          ps_n   = P_IDLE;
        end
      end
      P_WB: begin
        bus_req  = (lk_st == ST_M);
        bus_cmd  = BC_WB;
        bus_addr = {lk_tag, lk_idx};
        if (lk_st != ST_M || bus_gnt) begin
          pw_en = 1'b1;
          ps_n  = P_FILL;
        end
      end
      P_FILL: begin
        bus_req = 1'b1;
        bus_cmd = rq_we ? BC_RDX : BC_RD;
        if (bus_gnt)
          ps_n = P_DATA;
      end
      P_DATA: if (bus_data_vld) begin
        fill_evt = 1'b1;
        pw_en    = 1'b1;
        pw_st    = fill_state(rq_we, shared_in);
        pw_tag   = rq_addr[ADDR_W-1:IDX_W];
        done_d   = 1'b1;
        res_d    = pw_st;
        ps_n     = P_IDLE;
      end
      default: ps_n = P_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps      <= P_IDLE;
      rq_we   <= 1'b0;
      rq_addr <= '0;
      done_q  <= 1'b0;
      res_q   <= ST_I;
    end else begin
      ps     <= ps_n;
      done_q <= done_d;
      res_q  <= res_d;
      if (req_accept) begin
        rq_we   <= cpu_we;
        rq_addr <= cpu_addr;
      end
    end
  end

  assign cpu_done    = done_q;
  assign cpu_line_st = res_q;
  assign fill_store  = rq_we;
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c2c_en,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic [1:0]        cpu_line_st,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_data_vld,
  input  logic              shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush,
  output logic              snp_supply
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] lk_idx;
  line_st_t         lk_st, sn_st, pw_st, sw_st, res_st;
  logic [TAG_W-1:0] lk_tag, sn_tag, pw_tag;
  logic             pw_en, sw_en;
  bus_cmd_t         cmd_e;

  // named events for the checker
  logic fill_evt, fill_store, req_accept, snp_hit;

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (lk_idx),
    .rd_st  (lk_st),
    .rd_tag (lk_tag),
    .sn_idx (snp_addr[IDX_W-1:0]),
    .sn_st  (sn_st),
    .sn_tag (sn_tag),
    .pw_en  (pw_en),
    .pw_st  (pw_st),
    .pw_tag (pw_tag),
    .sw_en  (sw_en),
    .sw_st  (sw_st)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_tag   (snp_addr[ADDR_W-1:IDX_W]),
    .line_st   (sn_st),
    .line_tag  (sn_tag),
    .c2c_en    (c2c_en),
    .hit       (snp_hit),
    .shared_o  (snp_shared),
    .flush_o   (snp_flush),
    .supply_o  (snp_supply),
    .wr_en     (sw_en),
    .wr_st     (sw_st)
  );

  mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .snp_valid    (snp_valid),
    .bus_gnt      (bus_gnt),
    .bus_data_vld (bus_data_vld),
    .shared_in    (shared_in),
    .lk_st        (lk_st),
    .lk_tag       (lk_tag),
    .lk_idx       (lk_idx),
    .bus_req      (bus_req),
    .bus_cmd      (cmd_e),
    .bus_addr     (bus_addr),
    .pw_en        (pw_en),
    .pw_st        (pw_st),
    .pw_tag       (pw_tag),
    .cpu_done     (cpu_done),
    .cpu_line_st  (res_st),
    .fill_evt     (fill_evt),
    .fill_store   (fill_store),
    .req_accept   (req_accept)
  );

  assign bus_cmd     = cmd_e;
  assign cpu_line_st = res_st;
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              c2c_en,
  input logic              cpu_done,
  input logic [1:0]        cpu_line_st,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              shared_in,
  input logic              snp_valid,
  input logic              snp_shared,
  input logic              snp_flush,
  input logic              snp_supply,
  input logic              fill_evt,
  input logic              fill_store
);
  AST_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt && !fill_store && !shared_in |=> cpu_done && cpu_line_st == 2'd2); // R1
  AST_FILL_SHRD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt && !fill_store && shared_in |=> cpu_done && cpu_line_st == 2'd1); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R2
  AST_STORE_FILL_M: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt && fill_store |=> cpu_line_st == 2'd3); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && (bus_cmd == 2'd0 || bus_cmd == 2'd1)
      |=> bus_req && $stable(bus_cmd) && $stable(bus_addr)); // R3
  AST_UPG_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == 2'd2 |=> cpu_done && cpu_line_st == 2'd3); // R4
  AST_FLUSH_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_supply && snp_shared); // R5
  AST_SNP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |-> !snp_shared && !snp_flush && !snp_supply); // R8
  AST_CLEAN_NO_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply && !c2c_en |-> snp_flush); // R9
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .c2c_en      (c2c_en),
  .cpu_done    (cpu_done),
  .cpu_line_st (cpu_line_st),
  .bus_req     (bus_req),
  .bus_cmd     (bus_cmd),
  .bus_addr    (bus_addr),
  .bus_gnt     (bus_gnt),
  .shared_in   (shared_in),
  .snp_valid   (snp_valid),
  .snp_shared  (snp_shared),
  .snp_flush   (snp_flush),
  .snp_supply  (snp_supply),
  .fill_evt    (fill_evt),
  .fill_store  (fill_store)
);

// File: tb/mesi_snoop_ctrl_test.sv
module mesi_snoop_ctrl_test;
  localparam int AW = 12;
  localparam int SI = 0, SS = 1, SE = 2, SM = 3;
  localparam int CRD = 0, CRDX = 1, CUPG = 2, CWB = 3;

  logic clk = 1'b0, rst_n = 1'b0, c2c_en = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_done;
  logic [1:0] cpu_line_st;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic bus_gnt = 1'b0, bus_data_vld = 1'b0, shared_in = 1'b0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared, snp_flush, snp_supply;

  int n_checks = 0, n_errs = 0;
  int n_tx, tx_cmd[4], tx_adr[4], res_st, lag;
  int s_sh, s_fl, s_sp;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mesi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(3)) uut (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cpu_start(input bit we, input int adr);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(adr);
    n_tx = 0; lag = 0; res_st = -1;
  endtask

  // bus model: grant any request, a data beat follows reads
  task automatic cpu_finish(input bit sh);
    bit pend = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      bus_gnt = 1'b0; bus_data_vld = 1'b0; shared_in = 1'b0;
      lag++;
      if (cpu_done) begin
        res_st = int'(cpu_line_st);
        break;
      end
      if (pend) begin
        bus_data_vld = 1'b1; shared_in = sh; pend = 1'b0; lag = 0;
      end else if (bus_req) begin
        if (n_tx < 4) begin
          tx_cmd[n_tx] = int'(bus_cmd); tx_adr[n_tx] = int'(bus_addr);
        end
        n_tx++;
        bus_gnt = 1'b1; lag = 0;
        pend = (bus_cmd == 2'd0 || bus_cmd == 2'd1);
      end
    end
    cpu_req = 1'b0;
  endtask

  task automatic cpu_op(input bit we, input int adr, input bit sh);
    cpu_start(we, adr);
    cpu_finish(sh);
  endtask

  task automatic snoop(input int cmd, input int adr, input bit c2c);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = AW'(adr); c2c_en = c2c;
    #1;
    s_sh = int'(snp_shared); s_fl = int'(snp_flush); s_sp = int'(snp_supply);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(!cpu_done && !bus_req, "R11 idle after reset", int'(bus_req), 0);
    snoop(CRD, 'h010, 1'b1);
    chk(s_sh == 0 && s_sp == 0, "R11 snoop sees no line", s_sh, 0);
    cpu_op(1'b0, 'h010, 1'b0);
    chk(n_tx == 1 && tx_cmd[0] == CRD && tx_adr[0] == 'h010, "R11 R1 first load reads", n_tx, 1);
    chk(res_st == SE && lag == 1, "R1 install exclusive", res_st, SE);
  endtask

  task automatic t_hits;
    cpu_op(1'b0, 'h010, 1'b0);
    chk(n_tx == 0 && res_st == SE && lag == 1, "R2 load hit", res_st, SE);
    cpu_op(1'b1, 'h010, 1'b0);
    chk(n_tx == 0 && res_st == SM, "R2 store E silent", res_st, SM);
    cpu_op(1'b1, 'h010, 1'b0);
    chk(n_tx == 0 && res_st == SM, "R2 store M silent", n_tx, 0);
  endtask

  task automatic t_snoop_mod;
    snoop(CRD, 'h010, 1'b0);
    chk(s_fl == 1 && s_sp == 1 && s_sh == 1, "R5 read hits M", s_fl, 1);
    cpu_op(1'b0, 'h010, 1'b0);
    chk(n_tx == 0 && res_st == SS, "R5 M drops to S", res_st, SS);
  endtask

  task automatic t_shared_c2c;
    cpu_op(1'b0, 'h021, 1'b1);
    chk(res_st == SS && tx_cmd[0] == CRD, "R1 install shared", res_st, SS);
    snoop(CRD, 'h021, 1'b0);
    chk(s_sh == 1 && s_sp == 0 && s_fl == 0, "R9 R8 c2c off", s_sp, 0);
    snoop(CRD, 'h021, 1'b1);
    chk(s_sh == 1 && s_sp == 1 && s_fl == 0, "R9 c2c on", s_sp, 1);
    cpu_op(1'b1, 'h021, 1'b0);
    chk(n_tx == 1 && tx_cmd[0] == CUPG && tx_adr[0] == 'h021, "R4 upgrade issued", tx_cmd[0], CUPG);
    chk(res_st == SM && lag == 1, "R4 done at grant", lag, 1);
  endtask

  task automatic t_rdx;
    cpu_op(1'b1, 'h032, 1'b0);
    chk(n_tx == 1 && tx_cmd[0] == CRDX && res_st == SM, "R3 store miss", tx_cmd[0], CRDX);
    snoop(CRDX, 'h032, 1'b0);
    chk(s_fl == 1 && s_sh == 1, "R6 rdx flushes M", s_fl, 1);
    cpu_op(1'b0, 'h032, 1'b0);
    chk(n_tx == 1 && res_st == SE, "R6 line invalidated", n_tx, 1);
    snoop(CRD, 'h032, 1'b1);
    chk(s_sh == 1 && s_fl == 0 && s_sp == 1, "R7 R9 read hits E", s_fl, 0);
    cpu_op(1'b0, 'h032, 1'b0);
    chk(n_tx == 0 && res_st == SS, "R7 E demoted", res_st, SS);
    snoop(CRDX, 'h032, 1'b0);
    chk(s_sh == 1 && s_fl == 0 && s_sp == 0, "R6 rdx hits S", s_sp, 0);
    cpu_op(1'b0, 'h032, 1'b0);
    chk(n_tx == 1, "R6 S invalidated", n_tx, 1);
    cpu_op(1'b0, 'h043, 1'b1);
    snoop(CUPG, 'h043, 1'b0);
    chk(s_sh == 1 && s_fl == 0, "R6 upgrade snoop", s_sh, 1);
    cpu_op(1'b0, 'h043, 1'b0);
    chk(n_tx == 1, "R6 upgrade invalidates", n_tx, 1);
  endtask

  task automatic t_quiet;
    snoop(CRD, 'h0A3, 1'b1);
    chk(s_sh == 0 && s_sp == 0 && s_fl == 0, "R8 snoop miss", s_sh, 0);
    snoop(CWB, 'h043, 1'b1);
    chk(s_sh == 0 && s_sp == 0, "R8 write-back snoop", s_sh, 0);
    cpu_op(1'b0, 'h043, 1'b0);
    chk(n_tx == 0 && res_st == SE, "R8 line kept", res_st, SE);
  endtask

  task automatic t_replace;
    cpu_op(1'b1, 'h055, 1'b0);
    cpu_op(1'b0, 'h05D, 1'b0);
    chk(n_tx == 2 && tx_cmd[0] == CWB && tx_adr[0] == 'h055, "R10 write-back victim", tx_adr[0], 'h055);
    chk(tx_cmd[1] == CRD && tx_adr[1] == 'h05D && res_st == SE, "R10 fill after wb", tx_adr[1], 'h05D);
    cpu_op(1'b0, 'h055, 1'b0);
    chk(n_tx == 1 && tx_cmd[0] == CRD, "R10 clean victim silent", n_tx, 1);
  endtask

  task automatic t_order;
    cpu_start(1'b0, 'h055);
    snp_valid = 1'b1; snp_cmd = 2'(CRD); snp_addr = AW'('h055); c2c_en = 1'b0;
    #1;
    chk(snp_shared == 1'b1, "R12 R7 snoop in accept cycle", int'(snp_shared), 1);
    @(negedge clk);
    snp_valid = 1'b0;
    chk(cpu_done == 1'b0, "R12 request held back", int'(cpu_done), 0);
    cpu_finish(1'b0);
    chk(res_st == SS && n_tx == 0, "R12 snoop applied first", res_st, SS);
    cpu_op(1'b0, 'h066, 1'b1);
    cpu_start(1'b1, 'h066);
    @(negedge clk);
    chk(bus_req && bus_cmd == 2'(CUPG), "R4 upgrade pending", int'(bus_cmd), CUPG);
    snp_valid = 1'b1; snp_cmd = 2'(CRDX); snp_addr = AW'('h066);
    @(negedge clk);
    snp_valid = 1'b0;
    cpu_finish(1'b0);
    chk(n_tx == 1 && tx_cmd[0] == CRDX && res_st == SM, "R12 upgrade reissued", tx_cmd[0], CRDX);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hits();
    t_snoop_mod();
    t_shared_c2c();
    t_rdx();
    t_quiet();
    t_replace();
    t_order();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end
endmodule